// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder with Exception Classification

This block performs the register-to-register single-precision add of a floating-point unit. Before any arithmetic it sorts each operand into a class (zero, normal, denormal, infinity, quiet NaN, signalling NaN). A fixed priority then picks the outcome: signalling NaNs first, then quiet NaNs, then denormals, and only after those the class-based sum. Normal operands go through an aligned add or subtract with guard, round and sticky bits. Rounding is either to nearest-even or toward zero.

Each operation clears the cause field and rebuilds it. The new cause bits are ORed into sticky flag bits that clear only on an explicit write. A trap request and a destination write-enable tell the surrounding pipeline whether the result may be committed. A one-cycle `start` pulse launches the operation. All outputs are registered and are valid in the cycle after `start`, marked by `done`.

Bit layouts used throughout: `cause[4]` = unimplemented operation (E), `cause[3]`/`flags[3]`/`trap_en[3]` = invalid (V), bit 2 = overflow (O), bit 1 = underflow (U), bit 0 = inexact (I). A NaN has an all-ones exponent and a nonzero fraction. It is signalling when fraction bit 22 is 1 and quiet when fraction bit 22 is 0.

Top module: `fadd_unit`

## Requirements
- R1: A `start` in cycle t produces `done`=1 in cycle t+1 only. In that cycle the result, `cause`, `trap` and `dst_we` describe that operation alone, and `cause` holds none of the bits from earlier operations.
- R2: If either operand is a signalling NaN, `cause` is exactly V and the result is the canonical quiet NaN 0x7FBFFFFF. This holds even when the other operand is a quiet NaN or a denormal.
- R3: Otherwise, if either operand is a quiet NaN, the result is 0x7FBFFFFF and `cause` is zero, even when the other operand is denormal.
- R4: Otherwise, if either operand is denormal (zero exponent, nonzero fraction), `cause` is exactly E, `trap` is 1 and `dst_we` is 0.
- R5: Sums of normal operands are rounded to nearest with ties to even when `rnd_rz`=0, and truncated toward zero when `rnd_rz`=1. Any discarded nonzero bit sets I.
- R6: If the rounded exponent reaches 255, O and I are set. The result is infinity of the sum's sign when rounding to nearest, and the largest finite magnitude 0x7F7FFFFF with that sign when rounding toward zero.
- R7: If the normalised sum of normal operands has a biased exponent of 0 or less before rounding, the result is zero with the sum's sign, and U and I are set.
- R8: Infinity plus a finite value gives that infinity. Infinities of equal sign give that infinity. Infinities of opposite sign raise V and return 0x7FBFFFFF. Zero plus x gives x. Two zeros of equal sign give that zero. An exact zero from opposite-signed operands is +0 in both rounding modes.
- R9: If any of `trap_en[2:0]` (O, U, I) is set at `start`, `trap` is 1 with `done`, whether or not a cause bit is raised.
- R10: A V cause with `trap_en[3]`=1 raises `trap`. `dst_we` equals `done` AND NOT `trap`, so no result is committed when a trap is requested.
- R11: `flags` is sticky: each operation ORs `cause[3:0]` into it. `flag_wr` loads `flag_wdata` on the next edge. Otherwise `flags` never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one addition |
| op_a | input | 32 | First operand (source register) |
| op_b | input | 32 | Second operand (destination register's old value) |
| rnd_rz | input | 1 | 0: round to nearest even, 1: round toward zero |
| trap_en | input | 4 | Trap enables {V,O,U,I} |
| flag_wr | input | 1 | Load sticky flags from `flag_wdata` |
| flag_wdata | input | 4 | Value written to flags {V,O,U,I} |
| result | output | 32 | Sum or special value |
| dst_we | output | 1 | Commit result to destination |
| cause | output | 5 | Cause of last operation {E,V,O,U,I} |
| flags | output | 4 | Sticky flags {V,O,U,I} |
| trap | output | 1 | Trap request, valid with `done` |
| done | output | 1 | Result valid, one cycle after `start` |

## Verification
A wrong classification or a broken priority shows one cycle after `start` as a wrong `cause` pattern or a non-canonical NaN on `result`. The typical cases are a denormal beating a NaN, or a quiet NaN raising V. A rounding or alignment fault changes only the low result bits or the I bit in the same cycle, so the directed operands are chosen right at the tie and overflow boundaries. A fault in the sticky-flag register may stay hidden across many operations. It is exposed by clearing the flags, running a known sequence and comparing the accumulated value. Trap and commit faults show in the `done` cycle as `dst_we` and `trap` both set or both clear.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
  typedef enum logic [2:0] {
    CL_ZERO, CL_NORM, CL_DENORM, CL_INF, CL_QNAN, CL_SNAN
  } fclass_e;

  // bit positions in cause / flags / trap enables
  localparam int C_E = 4;
  localparam int C_V = 3;
  localparam int C_O = 2;
  localparam int C_U = 1;
  localparam int C_I = 0;
  localparam int CAUSE_W = 5;
  localparam int FLAG_W  = 4;
endpackage

// File: rtl/fadd_classify.sv
module fadd_classify
  import fadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] x,
  output fclass_e      cls
);
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;

  assign ex = x[W-2:FRAC_W];
  assign fr = x[FRAC_W-1:0];

  always_comb begin
    if (ex == '0)
      cls = (fr == '0) ? CL_ZERO : CL_DENORM;
    else if (ex == '1) begin
      if (fr == '0)              cls = CL_INF;
      else if (fr[FRAC_W-1])     cls = CL_SNAN;
      else                       cls = CL_QNAN;
    end else
      cls = CL_NORM;
  end
endmodule

// File: rtl/fadd_normal.sv
module fadd_normal #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W   = 1 + EXP_W + FRAC_W,
  localparam int MW  = FRAC_W + 1,
  localparam int XW  = MW + 3,
  localparam int LZW = $clog2(XW) + 1,
  localparam int EW  = EXP_W + 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         rz,
  output logic [W-1:0] res,
  output logic         ovf,
  output logic         unf,
  output logic         inx
);
  localparam logic [EXP_W-1:0]    XW_E   = EXP_W'(XW);
  localparam logic signed [EW-1:0] EMAX_S = EW'((1 << EXP_W) - 1);
  localparam logic signed [EW-1:0] ZERO_S = '0;

  logic [W-1:0]      big, sml;
  logic [EXP_W-1:0]  d;
  logic [XW-1:0]     bx, mbx, shifted, m;
  logic              stk, sub, sgn, found, inc;
  logic [XW:0]       sum;
  logic [LZW-1:0]    lz;
  logic signed [EW-1:0] e;
  logic [MW:0]       rm;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    // larger magnitude first; equal magnitudes keep a
    if (a[W-2:0] < b[W-2:0]) begin big = b; sml = a; end
    else                     begin big = a; sml = b; end
    sgn = big[W-1];
    sub = big[W-1] ^ sml[W-1];
    d   = big[W-2:FRAC_W] - sml[W-2:FRAC_W];
    bx  = {1'b1, big[FRAC_W-1:0], 3'b000};
    mbx = {1'b1, sml[FRAC_W-1:0], 3'b000};
    if (d >= XW_E) begin
      shifted = '0;
      stk     = 1'b1;
    end else begin
      shifted = mbx >> d;
      stk     = |(mbx & (({{(XW-1){1'b0}}, 1'b1} << d) - 1'b1));
    end
    shifted = shifted | {{(XW-1){1'b0}}, stk};
    sum = sub ? ({1'b0, bx} - {1'b0, shifted}) : ({1'b0, bx} + {1'b0, shifted});

    // normalise
    lz = '0;
    found = 1'b0;
    for (int i = XW - 1; i >= 0; i--) begin
      if (!found && sum[i]) begin
        lz = LZW'(XW - 1 - i);
        found = 1'b1;
      end
    end
    if (sum[XW]) begin
      m = sum[XW:1] | {{(XW-1){1'b0}}, sum[0]};
      e = EW'({2'b00, big[W-2:FRAC_W]}) + EW'(1);
    end else begin
      m = sum[XW-1:0] << lz;
      e = EW'({2'b00, big[W-2:FRAC_W]}) - EW'(lz);
    end

    // round
    inc = !rz && m[2] && (m[1] || m[0] || m[3]);
    rm  = {1'b0, m[XW-1:3]} + {{MW{1'b0}}, inc};
    if (rm[MW]) begin
      e    = e + EW'(1);
      frac = rm[MW-1:1];
    end else begin
      frac = rm[FRAC_W-1:0];
    end

    ovf = 1'b0;
    unf = 1'b0;
    inx = |m[2:0];
    if (sum == '0) begin
      res = '0;
      inx = 1'b0;
    end else if (e <= ZERO_S) begin
      res = {sgn, {(W-1){1'b0}}};
      unf = 1'b1;
      inx = 1'b1;
    end else if (e >= EMAX_S) begin
      ovf = 1'b1;
      inx = 1'b1;
      res = rz ? {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}}
               : {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      res = {sgn, e[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fadd_unit.sv
module fadd_unit
  import fadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [W-1:0]       op_a,
  input  logic [W-1:0]       op_b,
  input  logic               rnd_rz,
  input  logic [FLAG_W-1:0]  trap_en,
  input  logic               flag_wr,
  input  logic [FLAG_W-1:0]  flag_wdata,
  output logic [W-1:0]       result,
  output logic               dst_we,
  output logic [CAUSE_W-1:0] cause,
  output logic [FLAG_W-1:0]  flags,
  output logic               trap,
  output logic               done
);
  localparam logic [W-1:0] QNAN_C = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

  logic [W-1:0] ops [2];
  fclass_e      cls [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fadd_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .x   (ops[g]),
      .cls (cls[g])
    );
  end

  logic [W-1:0] n_res;
  logic         n_ovf, n_unf, n_inx;

  fadd_normal #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .a   (op_a),
    .b   (op_b),
    .rz  (rnd_rz),
    .res (n_res),
    .ovf (n_ovf),
    .unf (n_unf),
    .inx (n_inx)
  );

  // named classification events, also watched by the checker
  logic ev_snan, ev_qnan, ev_den, ev_inf_clash;
  assign ev_snan      = (cls[0] == CL_SNAN) || (cls[1] == CL_SNAN);
  assign ev_qnan      = (cls[0] == CL_QNAN) || (cls[1] == CL_QNAN);
  assign ev_den       = (cls[0] == CL_DENORM) || (cls[1] == CL_DENORM);
  assign ev_inf_clash = (cls[0] == CL_INF) && (cls[1] == CL_INF) && (op_a[W-1] != op_b[W-1]);

  logic [W-1:0]       res_n;
  logic [CAUSE_W-1:0] cause_n;
  logic               trap_n;

  always_comb begin
    cause_n = '0;
    res_n   = '0;
    if (ev_snan) begin
      cause_n[C_V] = 1'b1;
      res_n = QNAN_C;
    end else if (ev_qnan) begin
      res_n = QNAN_C;
    end else if (ev_den) begin
      cause_n[C_E] = 1'b1;
    end else if (ev_inf_clash) begin
      cause_n[C_V] = 1'b1;
      res_n = QNAN_C;
    end else if (cls[0] == CL_INF) begin
      res_n = op_a;
    end else if (cls[1] == CL_INF) begin
      res_n = op_b;
    end else if ((cls[0] == CL_ZERO) && (cls[1] == CL_ZERO)) begin
      res_n = {op_a[W-1] & op_b[W-1], {(W-1){1'b0}}};
    end else if (cls[0] == CL_ZERO) begin
      res_n = op_b;
    end else if (cls[1] == CL_ZERO) begin
      res_n = op_a;
    end else begin
      res_n = n_res;
      cause_n[C_O] = n_ovf;
      cause_n[C_U] = n_unf;
      cause_n[C_I] = n_inx;
    end
    trap_n = trap_en[C_O] | trap_en[C_U] | trap_en[C_I] | cause_n[C_E]
           | (cause_n[C_V] & trap_en[C_V]);
  end

  logic trap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
      cause  <= '0;
      trap_q <= 1'b0;
      flags  <= '0;
    end else begin
      done  <= start;
      flags <= (flag_wr ? flag_wdata : flags) | (start ? cause_n[FLAG_W-1:0] : '0);
      if (start) begin
        result <= res_n;
        cause  <= cause_n;
        trap_q <= trap_n;
      end
    end
  end

  assign trap   = done & trap_q;
  assign dst_we = done & ~trap_q;
endmodule

// File: rtl/fadd_unit_chk.sv
module fadd_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  trap_en,
  input logic        flag_wr,
  input logic [31:0] result,
  input logic        dst_we,
  input logic [4:0]  cause,
  input logic [3:0]  flags,
  input logic        trap,
  input logic        done,
  input logic        ev_snan,
  input logic        ev_qnan,
  input logic        ev_den
);
  p_done_follows_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_snan_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ev_snan) |=> (cause == 5'b01000));
  p_qnan_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ev_snan && ev_qnan) |=> (cause == 5'b00000 && result == 32'h7FBFFFFF));
  p_denorm_e_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ev_snan && !ev_qnan && ev_den) |=> (cause[4] && trap && !dst_we));
  p_ovf_inexact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cause[2]) |-> cause[0]);
  p_forced_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (trap_en[2:0] != 3'b000)) |=> trap);
  p_we_xor_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dst_we != trap));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!dst_we && !trap));
  p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !flag_wr) |=> $stable(flags));
  p_flags_grow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !flag_wr) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind fadd_unit fadd_unit_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .trap_en (trap_en),
  .flag_wr (flag_wr),
  .result  (result),
  .dst_we  (dst_we),
  .cause   (cause),
  .flags   (flags),
  .trap    (trap),
  .done    (done),
  .ev_snan (ev_snan),
  .ev_qnan (ev_qnan),
  .ev_den  (ev_den)
);

// File: tb/fadd_unit_bench.sv
module fadd_unit_bench;
  localparam time PERIOD = 10ns;
  localparam int  WATCHDOG_CYC = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        rnd_rz = 1'b0;
  logic [3:0]  trap_en = '0;
  logic        flag_wr = 1'b0;
  logic [3:0]  flag_wdata = '0;
  logic [31:0] result;
  logic        dst_we;
  logic [4:0]  cause;
  logic [3:0]  flags;
  logic        trap;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  fadd_unit u_fadd_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .rnd_rz(rnd_rz), .trap_en(trap_en), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .result(result), .dst_we(dst_we), .cause(cause), .flags(flags),
    .trap(trap), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation; samples at the falling edge after the capturing edge
  task automatic op(input logic [31:0] a, input logic [31:0] b, input logic rz,
                    input logic [3:0] en);
    @(negedge clk);
    op_a = a; op_b = b; rnd_rz = rz; trap_en = en; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // full check of one committed or trapped outcome
  task automatic expect_op(input string req, input logic [31:0] a, input logic [31:0] b,
                           input logic rz, input logic [3:0] en,
                           input logic [31:0] r, input logic [4:0] c, input logic t);
    op(a, b, rz, en);
    chk({req, " done"}, 32'(done), 32'd1);
    chk({req, " cause"}, 32'(cause), 32'(c));
    chk({req, " trap"}, 32'(trap), 32'(t));
    chk({req, " we"}, 32'(dst_we), 32'(!t));
    if (!t) chk({req, " result"}, result, r);
  endtask

  task automatic t_reset;
    chk("R1 reset done", 32'(done), 0);
    chk("R1 reset we", 32'(dst_we), 0);
    chk("R11 reset flags", 32'(flags), 0);
    chk("R1 reset cause", 32'(cause), 0);
  endtask

  task automatic t_pulse;
    expect_op("R1 add", 32'h3F800000, 32'h40000000, 0, 4'h0, 32'h40400000, 5'b00000, 0);
    @(negedge clk);
    chk("R1 done pulse", 32'(done), 0);
    chk("R10 we idle", 32'(dst_we), 0);
  endtask

  task automatic t_specials;
    expect_op("R2 snan", 32'h7FC00000, 32'h3F800000, 0, 4'h0, 32'h7FBFFFFF, 5'b01000, 0);
    expect_op("R2 snan over qnan", 32'h7F800001, 32'hFFC00005, 0, 4'h0, 32'h7FBFFFFF, 5'b01000, 0);
    expect_op("R2 snan over denorm", 32'h00000001, 32'h7FC00000, 0, 4'h0, 32'h7FBFFFFF, 5'b01000, 0);
    expect_op("R3 qnan", 32'h7F800001, 32'h3F800000, 0, 4'h0, 32'h7FBFFFFF, 5'b00000, 0);
    expect_op("R3 qnan over denorm", 32'h00000001, 32'hFF800123, 0, 4'h0, 32'h7FBFFFFF, 5'b00000, 0);
    expect_op("R4 denorm", 32'h00000001, 32'h3F800000, 0, 4'h0, 32'h0, 5'b10000, 1);
    expect_op("R1 cause cleared", 32'h3F800000, 32'h3F800000, 0, 4'h0, 32'h40000000, 5'b00000, 0);
  endtask

  task automatic t_round;
    expect_op("R5 rne up", 32'h3F800000, 32'h33C00000, 0, 4'h0, 32'h3F800001, 5'b00001, 0);
    expect_op("R5 rz trunc", 32'h3F800000, 32'h33C00000, 1, 4'h0, 32'h3F800000, 5'b00001, 0);
    expect_op("R5 tie even down", 32'h3F800000, 32'h33800000, 0, 4'h0, 32'h3F800000, 5'b00001, 0);
    expect_op("R5 tie even up", 32'h3F800001, 32'h33800000, 0, 4'h0, 32'h3F800002, 5'b00001, 0);
    expect_op("R5 sub borrow", 32'h40000000, 32'hBF800001, 0, 4'h0, 32'h3F7FFFFE, 5'b00000, 0);
  endtask

  task automatic t_range;
    expect_op("R6 ovf rne", 32'h7F7FFFFF, 32'h7F7FFFFF, 0, 4'h0, 32'h7F800000, 5'b00101, 0);
    expect_op("R6 ovf rz", 32'h7F7FFFFF, 32'h7F7FFFFF, 1, 4'h0, 32'h7F7FFFFF, 5'b00101, 0);
    expect_op("R6 ovf neg rz", 32'hFF7FFFFF, 32'hFF7FFFFF, 1, 4'h0, 32'hFF7FFFFF, 5'b00101, 0);
    expect_op("R7 unf", 32'h00C00000, 32'h80800000, 0, 4'h0, 32'h00000000, 5'b00011, 0);
    expect_op("R7 unf neg", 32'h80C00000, 32'h00800000, 0, 4'h0, 32'h80000000, 5'b00011, 0);
  endtask

  task automatic t_zero_inf;
    expect_op("R8 inf clash", 32'h7F800000, 32'hFF800000, 0, 4'h0, 32'h7FBFFFFF, 5'b01000, 0);
    expect_op("R8 inf plus one", 32'h3F800000, 32'h7F800000, 0, 4'h0, 32'h7F800000, 5'b00000, 0);
    expect_op("R8 neg infs", 32'hFF800000, 32'hFF800000, 0, 4'h0, 32'hFF800000, 5'b00000, 0);
    expect_op("R8 cancel rne", 32'h3F800000, 32'hBF800000, 0, 4'h0, 32'h00000000, 5'b00000, 0);
    expect_op("R8 cancel rz", 32'hBF800000, 32'h3F800000, 1, 4'h0, 32'h00000000, 5'b00000, 0);
    expect_op("R8 neg zeros", 32'h80000000, 32'h80000000, 0, 4'h0, 32'h80000000, 5'b00000, 0);
    expect_op("R8 mixed zeros", 32'h00000000, 32'h80000000, 0, 4'h0, 32'h00000000, 5'b00000, 0);
    expect_op("R8 zero plus x", 32'h00000000, 32'hC0400000, 0, 4'h0, 32'hC0400000, 5'b00000, 0);
  endtask

  task automatic t_trap;
    expect_op("R9 forced O", 32'h3F800000, 32'h40000000, 0, 4'b0100, 32'h0, 5'b00000, 1);
    expect_op("R9 forced U", 32'h3F800000, 32'h40000000, 0, 4'b0010, 32'h0, 5'b00000, 1);
    expect_op("R9 forced I", 32'h3F800000, 32'h40000000, 0, 4'b0001, 32'h0, 5'b00000, 1);
    expect_op("R10 V enabled", 32'h7FC00000, 32'h3F800000, 0, 4'b1000, 32'h0, 5'b01000, 1);
    expect_op("R10 V en no cause", 32'h3F800000, 32'h40000000, 0, 4'b1000, 32'h40400000, 5'b00000, 0);
  endtask

  task automatic t_flags;
    @(negedge clk);
    flag_wr = 1'b1; flag_wdata = 4'h0;
    @(negedge clk);
    flag_wr = 1'b0;
    chk("R11 clear", 32'(flags), 0);
    op(32'h3F800000, 32'h33C00000, 0, 4'h0);
    chk("R11 inexact sticks", 32'(flags), 32'h1);
    op(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 4'h0);
    chk("R11 accumulate", 32'(flags), 32'h5);
    op(32'h3F800000, 32'h40000000, 0, 4'h0);
    chk("R11 clean op keeps", 32'(flags), 32'h5);
    repeat (3) @(negedge clk);
    chk("R11 idle keeps", 32'(flags), 32'h5);
    flag_wr = 1'b1; flag_wdata = 4'hA;
    @(negedge clk);
    flag_wr = 1'b0;
    chk("R11 explicit write", 32'(flags), 32'hA);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pulse();
    t_specials();
    t_round();
    t_range();
    t_zero_inf();
    t_trap();
    t_flags();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule